// File: doc/BRIEF.md
# ADC Offset and Gain Correction Stage

This block sits behind the decimation filter of a sigma-delta converter. It takes one signed filter word per valid strobe and removes a calibrated offset. Before that subtraction the offset is scaled by a factor K, which is picked from the amplifier gain code, the power mode and the reference selection. The stage then applies a fractional gain coefficient, clamps the result to the output range, and encodes it as either bipolar (twos complement) or unipolar code.

Two calibration words are loaded through a small write port. The offset coefficient is at address 0 and the gain coefficient is at address 1. A sticky saturation flag records any clamped sample until the consumer signals that it has read the data. The pipeline accepts a new sample every cycle and returns each result after a fixed latency.

Top module: `adc_corr`

## Requirements
- R1: After reset the offset coefficient is 0x0000 and the gain coefficient is 0x5555. `outValid`, `outData` and `satFlag` are all 0.
- R2: The corrected value is `inData - offset*K*2^(DW-16)`. Here `offset` is the signed 16-bit coefficient, so a positive coefficient lowers the result.
- R3: In mode 0 (normal), `pgaCode` n selects an amplifier gain of 2^n. K is 2 for codes 1 and 7, 4 for code 8 and 8 for code 9.
- R4: In mode 1 (low power), K is 32 for code 7. In mode 2 (low power plus), K is 8 for code 9. In both cases K doubles when `halfRef` is 1.
- R5: Every other combination of mode, code and `halfRef` uses K = 1.
- R6: The gained value is floor(corrected * gain / 16384), with `gain` taken as an unsigned 16-bit value.
- R7: A gained value above 2^(DW-1)-1 clamps to that maximum. A value below -2^(DW-1) clamps to that minimum.
- R8: `satFlag` is set by every clamped output and holds until `dataRead` is 1 at a clock edge. If a set and a clear land on the same edge, the set wins.
- R9: With `unipolar` = 1 the MSB of the clamped twos complement code is inverted, so minimum maps to 0 and maximum maps to all ones.
- R10: A sample taken at a rising edge appears on `outValid`/`outData` after the third rising edge, counting the sampling edge. One sample per cycle is accepted.
- R11: A write to `regAddr` 0 (offset) or 1 (gain) takes effect only for samples taken at later edges. A sample taken at the same edge as the write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Filter word valid |
| inData | input | DW | Signed filter word |
| regWrEn | input | 1 | Coefficient write strobe |
| regAddr | input | 1 | 0 = offset, 1 = gain |
| regWrData | input | 16 | Coefficient write value |
| pgaCode | input | PGA_W | Amplifier gain code, gain = 2^code |
| pwrMode | input | 2 | 0 normal, 1 low power, 2 low power plus |
| halfRef | input | 1 | Half-supply reference selected |
| unipolar | input | 1 | 1 = unipolar coding, 0 = twos complement |
| dataRead | input | 1 | Consumer read, clears `satFlag` |
| outValid | output | 1 | Corrected word valid |
| outData | output | DW | Corrected, clamped and coded word |
| satFlag | output | 1 | Sticky saturation flag |

## Verification
The bench builds the block with DW = 16 and PGA_W = 4. With DW = 16 one offset LSB equals one input LSB, so each K factor shows up directly as a multiple of the offset in the output. A 4-bit code reaches every entry of the K table and also some codes outside it. At this width, inputs beyond ±0.75 of full scale already overflow under the reset gain, so both clamp directions can be driven from ordinary samples.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL      = 2'd0,
    MODE_LOWPWR      = 2'd1,
    MODE_LOWPWR_PLUS = 2'd2
  } pwr_mode_t;

  localparam int COEF_W    = 16;
  localparam int GAIN_FRAC = 14;
  localparam int KSHIFT_W  = 3;
  localparam logic [COEF_W-1:0] GAIN_RESET = 16'h5555;
  localparam logic [COEF_W-1:0] OFF_RESET  = 16'h0000;

  // strobes from control to datapath
  typedef struct packed {
    logic                       load;
    logic [KSHIFT_W-1:0]        kShift;
    logic signed [COEF_W-1:0]   offset;
    logic [COEF_W-1:0]          gain;
    logic                       unipolar;
    logic                       clearSticky;
  } ctl_strobe_t;

endpackage

// File: rtl/adc_corr_ctrl.sv
module adc_corr_ctrl
  import adc_corr_pkg::*;
#(
  parameter int PGA_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               regWrEn,
  input  logic               regAddr,
  input  logic [COEF_W-1:0]  regWrData,
  input  logic [PGA_W-1:0]   pgaCode,
  input  logic [1:0]         pwrMode,
  input  logic               halfRef,
  input  logic               unipolar,
  input  logic               dataRead,
  output ctl_strobe_t        ctl
);

  logic [COEF_W-1:0]   offsetQ;
  logic [COEF_W-1:0]   gainQ;
  logic [KSHIFT_W-1:0] kShift;
  int                  codeInt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsetQ <= OFF_RESET;
      gainQ   <= GAIN_RESET;
    end else if (regWrEn) begin
      if (regAddr) gainQ   <= regWrData;
      else         offsetQ <= regWrData;
    end
  end

  // K expressed as a left shift (log2 K)
  always_comb begin
    codeInt = int'(pgaCode);
    kShift  = 3'd0;
    case (pwr_mode_t'(pwrMode))
      MODE_NORMAL: begin
        if (codeInt == 1 || codeInt == 7) kShift = 3'd1;
        else if (codeInt == 8)            kShift = 3'd2;
        else if (codeInt == 9)            kShift = 3'd3;
      end
      MODE_LOWPWR: begin
        if (codeInt == 7) kShift = halfRef ? 3'd6 : 3'd5;
      end
      MODE_LOWPWR_PLUS: begin
        if (codeInt == 9) kShift = halfRef ? 3'd4 : 3'd3;
      end
      default: kShift = 3'd0;
    endcase
  end

  always_comb begin
    ctl.load        = inValid;
    ctl.kShift      = kShift;
    ctl.offset      = offsetQ;
    ctl.gain        = gainQ;
    ctl.unipolar    = unipolar;
    ctl.clearSticky = dataRead;
  end

  // coefficients only move on a write strobe
  assert_regs_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ($stable(offsetQ) && $stable(gainQ)));

endmodule

// File: rtl/adc_corr_dp.sv
module adc_corr_dp
  import adc_corr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic signed [DW-1:0] inData,
  input  ctl_strobe_t          ctl,
  output logic                 outValid,
  output logic [DW-1:0]        outData,
  output logic                 satFlag
);

  localparam int OFF_SHIFT = DW - COEF_W;
  localparam int CW        = DW + 8;
  localparam int PW        = CW + COEF_W + 1;
  localparam int HB        = PW - DW + 1;

  // stage 1: offset removal
  logic signed [CW-1:0] inExt, offExt, offTerm, corr1;
  logic                 v1, uni1;
  logic [COEF_W-1:0]    gain1;

  always_comb begin
    inExt   = CW'(inData);
    offExt  = CW'($signed(ctl.offset));
    offTerm = offExt <<< (int'(ctl.kShift) + OFF_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0; corr1 <= '0; gain1 <= '0; uni1 <= 1'b0;
    end else begin
      v1 <= ctl.load;
      if (ctl.load) begin
        corr1 <= inExt - offTerm;
        gain1 <= ctl.gain;
        uni1  <= ctl.unipolar;
      end
    end
  end

  // stage 2: gain multiply
  logic signed [PW-1:0] prodFull, prod2;
  logic                 v2, uni2;

  always_comb prodFull = PW'(corr1) * PW'($signed({1'b0, gain1}));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v2 <= 1'b0; prod2 <= '0; uni2 <= 1'b0;
    end else begin
      v2 <= v1;
      if (v1) begin
        prod2 <= prodFull;
        uni2  <= uni1;
      end
    end
  end

  // stage 3: normalise, clamp, code
  logic signed [PW-1:0] scaled;
  logic [HB-1:0]        hiBits;
  logic                 ovfPos, ovfNeg;
  logic [DW-1:0]        clamped, coded;
  logic                 satQ, uniQ;

  always_comb begin
    scaled = prod2 >>> GAIN_FRAC;
    hiBits = scaled[PW-1:DW-1];
    ovfPos = !scaled[PW-1] && (|hiBits);
    ovfNeg = scaled[PW-1] && !(&hiBits);
    if (ovfPos)      clamped = {1'b0, {(DW-1){1'b1}}};
    else if (ovfNeg) clamped = {1'b1, {(DW-1){1'b0}}};
    else             clamped = scaled[DW-1:0];
    coded = uni2 ? {~clamped[DW-1], clamped[DW-2:0]} : clamped;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0; outData <= '0; satFlag <= 1'b0;
      satQ <= 1'b0; uniQ <= 1'b0;
    end else begin
      outValid <= v2;
      satQ     <= v2 && (ovfPos || ovfNeg);
      if (v2) begin
        outData <= coded;
        uniQ    <= uni2;
      end
      if (v2 && (ovfPos || ovfNeg)) satFlag <= 1'b1;
      else if (ctl.clearSticky)     satFlag <= 1'b0;
    end
  end

  logic [DW-1:0] bipView;
  always_comb bipView = uniQ ? {~outData[DW-1], outData[DW-2:0]} : outData;

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> ##3 outValid);

  assert_clamp_R7: assert property (@(posedge clk) disable iff (!rstN)
    satQ |-> (bipView == {1'b0, {(DW-1){1'b1}}} || bipView == {1'b1, {(DW-1){1'b0}}}));

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (satFlag && !ctl.clearSticky) |=> satFlag);

  assert_sticky_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    satQ |-> satFlag);

endmodule

// File: rtl/adc_corr.sv
module adc_corr
  import adc_corr_pkg::*;
#(
  parameter int DW    = 16,
  parameter int PGA_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic signed [DW-1:0] inData,
  input  logic                 regWrEn,
  input  logic                 regAddr,
  input  logic [15:0]          regWrData,
  input  logic [PGA_W-1:0]     pgaCode,
  input  logic [1:0]           pwrMode,
  input  logic                 halfRef,
  input  logic                 unipolar,
  input  logic                 dataRead,
  output logic                 outValid,
  output logic [DW-1:0]        outData,
  output logic                 satFlag
);

  ctl_strobe_t ctl;

  adc_corr_ctrl #(.PGA_W(PGA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .pgaCode(pgaCode), .pwrMode(pwrMode), .halfRef(halfRef),
    .unipolar(unipolar), .dataRead(dataRead), .ctl(ctl)
  );

  adc_corr_dp #(.DW(DW)) i_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .ctl(ctl),
    .outValid(outValid), .outData(outData), .satFlag(satFlag)
  );

endmodule

// File: tb/test_adc_corr.sv
module test_adc_corr;

  logic               clk = 1'b0;
  logic               rstN;
  logic               inValid;
  logic signed [15:0] inData;
  logic               regWrEn;
  logic               regAddr;
  logic [15:0]        regWrData;
  logic [3:0]         pgaCode;
  logic [1:0]         pwrMode;
  logic               halfRef;
  logic               unipolar;
  logic               dataRead;
  logic               outValid;
  logic [15:0]        outData;
  logic               satFlag;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  adc_corr #(.DW(16), .PGA_W(4)) i_adc_corr (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .pgaCode(pgaCode), .pwrMode(pwrMode), .halfRef(halfRef),
    .unipolar(unipolar), .dataRead(dataRead),
    .outValid(outValid), .outData(outData), .satFlag(satFlag)
  );

  typedef struct packed {
    logic [15:0] din;
    logic [15:0] off;
    logic [15:0] gain;
    logic [3:0]  pga;
    logic [1:0]  mode;
    logic        half;
    logic        uni;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{16'h2000, 16'h0000, 16'h5555, 4'd0, 2'd0, 1'b0, 1'b0}, // R6 nominal
    '{16'h6000, 16'h0000, 16'h5555, 4'd0, 2'd0, 1'b0, 1'b0}, // R6 +0.75
    '{16'hA000, 16'h0000, 16'h5555, 4'd0, 2'd0, 1'b0, 1'b0}, // R6 -0.75
    '{16'h7FFF, 16'h0000, 16'h5555, 4'd0, 2'd0, 1'b0, 1'b0}, // R7 high clamp
    '{16'h8000, 16'h0000, 16'h5555, 4'd0, 2'd0, 1'b0, 1'b0}, // R7 low clamp
    '{16'h1000, 16'h0100, 16'h4000, 4'd8, 2'd0, 1'b0, 1'b0}, // R3 K=4
    '{16'h1000, 16'h0010, 16'h4000, 4'd7, 2'd1, 1'b0, 1'b0}, // R4 K=32
    '{16'h1000, 16'h0010, 16'h4000, 4'd7, 2'd1, 1'b1, 1'b0}, // R4 K=64
    '{16'h1000, 16'h0010, 16'h4000, 4'd9, 2'd2, 1'b1, 1'b0}, // R4 K=16
    '{16'h0000, 16'hFFF0, 16'h4000, 4'd1, 2'd0, 1'b0, 1'b1}, // R2 R3 negative offset, K=2, R9
    '{16'h1000, 16'h0010, 16'h4000, 4'd3, 2'd1, 1'b1, 1'b0}, // R5 uncovered, K=1
    '{16'h0000, 16'h0000, 16'h4000, 4'd0, 2'd0, 1'b0, 1'b1}, // R9 mid code
    '{16'h7FFF, 16'h0000, 16'h5555, 4'd0, 2'd0, 1'b0, 1'b1}, // R9 R7 max
    '{16'h8000, 16'h0000, 16'h5555, 4'd0, 2'd0, 1'b0, 1'b1}  // R9 R7 min
  };

  // reference model from the requirements
  function automatic logic [15:0] model(input logic [15:0] din, input logic [15:0] off,
      input logic [15:0] gain, input logic [3:0] pga, input logic [1:0] mode,
      input logic half, input logic uni, output logic sat);
    longint k, corr, prod, res;
    logic [15:0] r;
    k = 1;
    if (mode == 2'd0) begin
      if (pga == 4'd1 || pga == 4'd7) k = 2;
      else if (pga == 4'd8) k = 4;
      else if (pga == 4'd9) k = 8;
    end else if (mode == 2'd1 && pga == 4'd7) k = half ? 64 : 32;
    else if (mode == 2'd2 && pga == 4'd9) k = half ? 16 : 8;
    corr = longint'($signed(din)) - longint'($signed(off)) * k;
    prod = corr * longint'(gain);
    res  = prod >>> 14;
    sat  = 1'b0;
    if (res > 32767)       begin res = 32767;  sat = 1'b1; end
    else if (res < -32768) begin res = -32768; sat = 1'b1; end
    r = res[15:0];
    if (uni) r[15] = ~r[15];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic addr, input logic [15:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // drive one sample and leave the time at the negedge where the result shows
  task automatic runSample(input logic [15:0] din);
    @(negedge clk);
    inValid = 1'b1; inData = din;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulseRead();
    dataRead = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dataRead = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic        sat;
    logic [15:0] exp, expB;
    string       tag;
    rstN = 1'b0; inValid = 1'b0; inData = '0; regWrEn = 1'b0; regAddr = 1'b0;
    regWrData = '0; pgaCode = '0; pwrMode = '0; halfRef = 1'b0; unipolar = 1'b0;
    dataRead = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 outValid", 32'(outValid), 32'd0);
    check("R1 outData", 32'(outData), 32'd0);
    check("R1 satFlag", 32'(satFlag), 32'd0);
    rstN = 1'b1;

    // R1: reset coefficients give zero offset and 0x5555 gain
    runSample(16'h6000);
    exp = model(16'h6000, 16'h0000, 16'h5555, 4'd0, 2'd0, 1'b0, 1'b0, sat);
    check("R1 outValid after sample", 32'(outValid), 32'd1);
    check("R1 reset coefficients", 32'(outData), 32'(exp));

    for (int i = 0; i < NVEC; i++) begin
      writeReg(1'b0, VEC[i].off);
      writeReg(1'b1, VEC[i].gain);
      pgaCode = VEC[i].pga; pwrMode = VEC[i].mode;
      halfRef = VEC[i].half; unipolar = VEC[i].uni;
      runSample(VEC[i].din);
      exp = model(VEC[i].din, VEC[i].off, VEC[i].gain, VEC[i].pga,
                  VEC[i].mode, VEC[i].half, VEC[i].uni, sat);
      tag = sat ? "R7" : (VEC[i].uni ? "R9" : "R2/R6");
      check($sformatf("%s R10 valid vec %0d", tag, i), 32'(outValid), 32'd1);
      check($sformatf("%s data vec %0d", tag, i), 32'(outData), 32'(exp));
      check($sformatf("R8 flag vec %0d", i), 32'(satFlag), 32'(sat));
      pulseRead();
    end

    // R8: flag sticks through a clean sample, clears on read
    writeReg(1'b0, 16'h0000);
    writeReg(1'b1, 16'h5555);
    pgaCode = '0; pwrMode = '0; halfRef = 1'b0; unipolar = 1'b0;
    runSample(16'h7FFF);
    check("R8 set", 32'(satFlag), 32'd1);
    runSample(16'h1000);
    check("R8 holds without read", 32'(satFlag), 32'd1);
    pulseRead();
    check("R8 cleared by read", 32'(satFlag), 32'd0);

    // R10: back-to-back samples, exact latency
    writeReg(1'b1, 16'h4000);
    @(negedge clk);
    inValid = 1'b1; inData = 16'h0100;
    @(posedge clk); @(negedge clk);
    inData = 16'h0200;
    @(posedge clk); @(negedge clk);
    inData = 16'h0300;
    check("R10 not early", 32'(outValid), 32'd0);
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
    check("R10 first valid", 32'(outValid), 32'd1);
    check("R10 first data", 32'(outData), 32'h0100);
    @(posedge clk); @(negedge clk);
    check("R10 second data", 32'(outData), 32'h0200);
    @(posedge clk); @(negedge clk);
    check("R10 third data", 32'(outData), 32'h0300);
    @(posedge clk); @(negedge clk);
    check("R10 valid drops", 32'(outValid), 32'd0);

    // R11: write on the same edge as a sample affects only the next one
    @(negedge clk);
    inValid = 1'b1; inData = 16'h1000;
    regWrEn = 1'b1; regAddr = 1'b0; regWrData = 16'h0100;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
    @(posedge clk); @(negedge clk);
    exp  = model(16'h1000, 16'h0000, 16'h4000, 4'd0, 2'd0, 1'b0, 1'b0, sat);
    check("R11 same-edge sample uses old offset", 32'(outData), 32'(exp));
    @(posedge clk); @(negedge clk);
    expB = model(16'h1000, 16'h0100, 16'h4000, 4'd0, 2'd0, 1'b0, 1'b0, sat);
    check("R11 later sample uses new offset", 32'(outData), 32'(expB));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule